// File: doc/BRIEF.md
# DMA Command Translator with Fault Path

This block sits on the peripheral side of an I/O bridge. It takes multi-flit DMA command packets that peripherals issue. It asks an external translation engine to map the packet's virtual address, then forwards every flit to a memory-side command output. Each forwarded flit carries the translated line address. A packet whose physical address lands inside a configurable interrupt window does not go to memory. Each of its flits is instead sent as a single-word interrupt write on a separate output.

When translation is switched off, the virtual address is zero-extended and used as is. A translation miss stalls the packet, and the packet is translated again once the engine reports the entry as installed. A page fault, or a write to a read-only page, starts a fixed sequence:
- every remaining flit up to the end-of-packet flit is consumed and discarded;
- an IOMMU interrupt write is sent, but only when enabled;
- an error response goes back to the requester.

The faulty virtual address, the source ID and an error type code stay visible on diagnostic outputs.

Top module: `dmx_translator`

## Requirements
- R1: While reset is held and right after it, `in_ready`, `tr_req`, `mem_valid`, `wti_valid` and `rsp_valid` are low, and `err_type`, `bad_vaddr` and `bad_srcid` are zero.
- R2: With `xlat_en` high, a pending first flit in idle raises `tr_req` with `tr_vaddr` equal to its address. No flit is consumed before `tr_done` is seen.
- R3: On a translation hit outside the window, every flit of the packet appears on the memory output in order. Each flit's address is the translated address's bits above the 64-byte line offset (bits 5:0) joined with that flit's own bits 5:0. Data, write flag, source, thread and packet IDs and end-of-packet pass unchanged, and `in_ready` follows `mem_ready`.
- R4: With `xlat_en` low, `tr_req` stays low and the physical address is the virtual address zero-extended to the physical width.
- R5: When the physical address ANDed with the window mask equals the window base, each flit goes out on the interrupt-write output instead. It carries data bits 31:0, the request's source and thread IDs and packet ID 0x4. Nothing appears on the memory output.
- R6: A miss result (`tr_miss` without fault) stalls the packet with `in_ready` low and no output until `tr_fill` pulses. The packet is then translated again and proceeds.
- R7: A fault result (`tr_fault`) sets `err_type` to 1. A hit on a page reported not writable (`tr_writable` low) for a write sets `err_type` to 2, while the same page read is forwarded normally. Both latch `bad_vaddr` and `bad_srcid` from the packet, and these hold until the next fault.
- R8: After a fault, every flit up to and including the end-of-packet flit is accepted and discarded, without memory or peripheral interrupt output.
- R9: If `irq_en` is high when the end-of-packet flit of a faulty packet is accepted, exactly one interrupt write follows before the error response. It carries address {`irq_addr_hi`,`irq_addr_lo`} truncated to the physical width, data equal to the faulty virtual address, the bridge's own source ID, thread ID 0 and packet ID 0xC. With `irq_en` low, no such write occurs.
- R10: A faulty packet produces exactly one error response that echoes its source, thread and packet IDs with `rsp_error` = 1. The response holds until accepted, and the block then returns to idle.
- R11: At most one of `mem_valid`, `wti_valid` and `rsp_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable, sampled at packet start |
| irq_en | input | 1 | Enable for the IOMMU fault interrupt write |
| irq_addr_lo | input | 32 | Fault interrupt target address, low word |
| irq_addr_hi | input | 32 | Fault interrupt target address, high word |
| in_valid | input | 1 | Command flit valid |
| in_ready | output | 1 | Command flit accepted |
| in_addr | input | VA_W | Flit virtual address |
| in_wdata | input | DATA_W | Flit write data |
| in_write | input | 1 | Packet is a write |
| in_srcid | input | SRC_W | Requester source ID |
| in_trdid | input | TRD_W | Requester thread ID |
| in_pktid | input | PKT_W | Requester packet ID |
| in_eop | input | 1 | Last flit of packet |
| tr_req | output | 1 | Translation request |
| tr_vaddr | output | VA_W | Address to translate |
| tr_done | input | 1 | Translation result valid |
| tr_miss | input | 1 | Result is a miss |
| tr_fault | input | 1 | Result is a page fault |
| tr_writable | input | 1 | Translated page is writable |
| tr_paddr | input | PA_W | Translated address |
| tr_fill | input | 1 | Missing entry installed |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory command accepted |
| mem_addr | output | PA_W | Memory command address |
| mem_wdata | output | DATA_W | Memory command data |
| mem_write | output | 1 | Memory command is a write |
| mem_srcid | output | SRC_W | Memory command source ID |
| mem_trdid | output | TRD_W | Memory command thread ID |
| mem_pktid | output | PKT_W | Memory command packet ID |
| mem_eop | output | 1 | Memory command last flit |
| wti_valid | output | 1 | Interrupt write valid |
| wti_ready | input | 1 | Interrupt write accepted |
| wti_addr | output | PA_W | Interrupt write address |
| wti_data | output | WTI_W | Interrupt write data |
| wti_srcid | output | SRC_W | Interrupt write source ID |
| wti_trdid | output | TRD_W | Interrupt write thread ID |
| wti_pktid | output | PKT_W | Interrupt write packet ID |
| rsp_valid | output | 1 | Error response valid |
| rsp_ready | input | 1 | Error response accepted |
| rsp_srcid | output | SRC_W | Response source ID |
| rsp_trdid | output | TRD_W | Response thread ID |
| rsp_pktid | output | PKT_W | Response packet ID |
| rsp_error | output | 2 | Response error code |
| bad_vaddr | output | VA_W | Last faulty virtual address |
| bad_srcid | output | SRC_W | Last faulty source ID |
| err_type | output | 2 | Last fault type (1 page fault, 2 read-only) |

## Verification
The bench builds the block with its default parameters. These are a 32-bit virtual address, a 40-bit physical address, 64-bit data, 32-bit interrupt data, a 64-byte line and the interrupt window enabled over 16 MB of physical space. The physical width is wider than the virtual one, so both the zero-extension path and the truncation of the 64-bit interrupt target address are exercised. The window holds under both translation modes, so peripheral interrupt steering can be reached with translation on and off. A packet starting anywhere in the line with up to four flits covers line-offset splicing across the full 6-bit offset.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FWD_MEM,
      ST_FWD_WTI,
      ST_DRAIN,
      ST_IRQ_WR,
      ST_ERR_RSP,
      ST_MISS_WAIT
   } dmx_state_e;

   localparam logic [1:0] FLT_NONE   = 2'd0;
   localparam logic [1:0] FLT_PAGE   = 2'd1;
   localparam logic [1:0] FLT_RDONLY = 2'd2;

   localparam logic [3:0] PKT_PERIPH_WTI = 4'h4;
   localparam logic [3:0] PKT_FAULT_WTI  = 4'hC;

   localparam logic [1:0] RSP_ERR_CODE = 2'b01;

endpackage

// File: rtl/dmx_addr_map.sv
module dmx_addr_map #(
   parameter int          VA_W     = 32,
   parameter int          PA_W     = 40,
   parameter bit          WIN_EN   = 1'b1,
   parameter logic [39:0] WIN_BASE = 40'h00_C000_0000,
   parameter logic [39:0] WIN_MASK = 40'hFF_FF00_0000
) (
   input  logic            xlat_en,
   input  logic [VA_W-1:0] vaddr,
   input  logic [PA_W-1:0] tr_paddr,
   output logic [PA_W-1:0] paddr,
   output logic            in_window
);
   localparam int PAD_W = PA_W - VA_W;

   logic [PA_W-1:0] pass_addr;

   generate
      if (PAD_W > 0) begin : g_pad
         assign pass_addr = {{PAD_W{1'b0}}, vaddr};
      end else begin : g_same
         assign pass_addr = vaddr;
      end
   endgenerate

   assign paddr = xlat_en ? tr_paddr : pass_addr;

   generate
      if (WIN_EN) begin : g_win
         localparam logic [PA_W-1:0] BASE_P = PA_W'(WIN_BASE);
         localparam logic [PA_W-1:0] MASK_P = PA_W'(WIN_MASK);
         assign in_window = ((paddr & MASK_P) == BASE_P);
      end else begin : g_nowin
         assign in_window = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dmx_fault_log.sv
module dmx_fault_log #(
   parameter int VA_W  = 32,
   parameter int SRC_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             log_en,
   input  logic [1:0]       code,
   input  logic [VA_W-1:0]  vaddr,
   input  logic [SRC_W-1:0] srcid,
   output logic [VA_W-1:0]  bad_vaddr,
   output logic [SRC_W-1:0] bad_srcid,
   output logic [1:0]       err_type
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bad_vaddr <= '0;
         bad_srcid <= '0;
         err_type  <= '0;
      end else if (log_en) begin
         bad_vaddr <= vaddr;
         bad_srcid <= srcid;
         err_type  <= code;
      end
   end
endmodule

// File: rtl/dmx_ctrl_fsm.sv
module dmx_ctrl_fsm
   import dmx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xlat_en,
   input  logic       irq_en,
   input  logic       in_valid,
   input  logic       in_eop,
   input  logic       in_write,
   input  logic       tr_done,
   input  logic       tr_miss,
   input  logic       tr_fault,
   input  logic       tr_writable,
   input  logic       tr_fill,
   input  logic       in_window,
   input  logic       mem_ready,
   input  logic       wti_ready,
   input  logic       rsp_ready,
   output dmx_state_e state,
   output logic       hdr_take,
   output logic       log_fault,
   output logic [1:0] fault_code
);
   dmx_state_e nxt;
   logic       fault_now;

   assign fault_now  = tr_fault || (in_write && !tr_writable);
   assign fault_code = tr_fault ? FLT_PAGE : FLT_RDONLY;

   always_comb begin
      nxt       = state;
      hdr_take  = 1'b0;
      log_fault = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (in_valid) begin
               if (!xlat_en) begin
                  hdr_take = 1'b1;
                  nxt      = in_window ? ST_FWD_WTI : ST_FWD_MEM;
               end else if (tr_done) begin
                  if (fault_now) begin
                     log_fault = 1'b1;
                     nxt       = ST_DRAIN;
                  end else if (tr_miss) begin
                     nxt = ST_MISS_WAIT;
                  end else begin
                     hdr_take = 1'b1;
                     nxt      = in_window ? ST_FWD_WTI : ST_FWD_MEM;
                  end
               end
            end
         end
         ST_FWD_MEM:   if (in_valid && mem_ready && in_eop) nxt = ST_IDLE;
         ST_FWD_WTI:   if (in_valid && wti_ready && in_eop) nxt = ST_IDLE;
         ST_DRAIN:     if (in_valid && in_eop) nxt = irq_en ? ST_IRQ_WR : ST_ERR_RSP;
         ST_IRQ_WR:    if (wti_ready) nxt = ST_ERR_RSP;
         ST_ERR_RSP:   if (rsp_ready) nxt = ST_IDLE;
         ST_MISS_WAIT: if (tr_fill) nxt = ST_IDLE;
         default:      nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/dmx_translator.sv
module dmx_translator
   import dmx_pkg::*;
#(
   parameter int          VA_W       = 32,
   parameter int          PA_W       = 40,
   parameter int          DATA_W     = 64,
   parameter int          WTI_W      = 32,
   parameter int          SRC_W      = 14,
   parameter int          TRD_W      = 4,
   parameter int          PKT_W      = 8,
   parameter int          LINE_BYTES = 64,
   parameter bit          WIN_EN     = 1'b1,
   parameter logic [39:0] WIN_BASE   = 40'h00_C000_0000,
   parameter logic [39:0] WIN_MASK   = 40'hFF_FF00_0000,
   parameter logic [13:0] OWN_SRCID  = 14'h2A5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xlat_en,
   input  logic              irq_en,
   input  logic [31:0]       irq_addr_lo,
   input  logic [31:0]       irq_addr_hi,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [VA_W-1:0]   in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic              in_write,
   input  logic [SRC_W-1:0]  in_srcid,
   input  logic [TRD_W-1:0]  in_trdid,
   input  logic [PKT_W-1:0]  in_pktid,
   input  logic              in_eop,
   output logic              tr_req,
   output logic [VA_W-1:0]   tr_vaddr,
   input  logic              tr_done,
   input  logic              tr_miss,
   input  logic              tr_fault,
   input  logic              tr_writable,
   input  logic [PA_W-1:0]   tr_paddr,
   input  logic              tr_fill,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [PA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_write,
   output logic [SRC_W-1:0]  mem_srcid,
   output logic [TRD_W-1:0]  mem_trdid,
   output logic [PKT_W-1:0]  mem_pktid,
   output logic              mem_eop,
   output logic              wti_valid,
   input  logic              wti_ready,
   output logic [PA_W-1:0]   wti_addr,
   output logic [WTI_W-1:0]  wti_data,
   output logic [SRC_W-1:0]  wti_srcid,
   output logic [TRD_W-1:0]  wti_trdid,
   output logic [PKT_W-1:0]  wti_pktid,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [SRC_W-1:0]  rsp_srcid,
   output logic [TRD_W-1:0]  rsp_trdid,
   output logic [PKT_W-1:0]  rsp_pktid,
   output logic [1:0]        rsp_error,
   output logic [VA_W-1:0]   bad_vaddr,
   output logic [SRC_W-1:0]  bad_srcid,
   output logic [1:0]        err_type
);
   localparam int OFS_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = PA_W - OFS_W;

   generate
      if (PA_W < VA_W)                        begin : g_chk_pa  $error("PA_W must not be below VA_W"); end
      if (PA_W > 64)                          begin : g_chk_pa2 $error("PA_W must fit the 64-bit target"); end
      if ((1 << OFS_W) != LINE_BYTES)         begin : g_chk_ln  $error("LINE_BYTES must be a power of two"); end
      if (VA_W <= OFS_W)                      begin : g_chk_va  $error("VA_W must exceed the line offset"); end
      if (WTI_W > DATA_W)                     begin : g_chk_wd  $error("WTI_W must not exceed DATA_W"); end
      if (PKT_W < 4)                          begin : g_chk_pk  $error("PKT_W must hold the interrupt codes"); end
      if (SRC_W > 14)                         begin : g_chk_sr  $error("SRC_W must fit OWN_SRCID"); end
   endgenerate

   dmx_state_e       state;
   logic             hdr_take;
   logic             log_fault;
   logic [1:0]       fault_code;
   logic [PA_W-1:0]  paddr;
   logic             in_window;
   logic [LINE_W-1:0] pa_line;
   logic [SRC_W-1:0] h_srcid;
   logic [TRD_W-1:0] h_trdid;
   logic [PKT_W-1:0] h_pktid;
   logic [63:0]      irq_full;
   logic [PA_W-1:0]  flit_paddr;

   dmx_addr_map #(
      .VA_W(VA_W), .PA_W(PA_W), .WIN_EN(WIN_EN),
      .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)
   ) u_map (
      .xlat_en  (xlat_en),
      .vaddr    (in_addr),
      .tr_paddr (tr_paddr),
      .paddr    (paddr),
      .in_window(in_window)
   );

   dmx_ctrl_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .xlat_en    (xlat_en),
      .irq_en     (irq_en),
      .in_valid   (in_valid),
      .in_eop     (in_eop),
      .in_write   (in_write),
      .tr_done    (tr_done),
      .tr_miss    (tr_miss),
      .tr_fault   (tr_fault),
      .tr_writable(tr_writable),
      .tr_fill    (tr_fill),
      .in_window  (in_window),
      .mem_ready  (mem_ready),
      .wti_ready  (wti_ready),
      .rsp_ready  (rsp_ready),
      .state      (state),
      .hdr_take   (hdr_take),
      .log_fault  (log_fault),
      .fault_code (fault_code)
   );

   dmx_fault_log #(.VA_W(VA_W), .SRC_W(SRC_W)) u_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .log_en   (log_fault),
      .code     (fault_code),
      .vaddr    (in_addr),
      .srcid    (in_srcid),
      .bad_vaddr(bad_vaddr),
      .bad_srcid(bad_srcid),
      .err_type (err_type)
   );

   // Header latches: line base on acceptance, reply IDs on fault.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pa_line <= '0;
         h_srcid <= '0;
         h_trdid <= '0;
         h_pktid <= '0;
      end else begin
         if (hdr_take) pa_line <= paddr[PA_W-1:OFS_W];
         if (log_fault) begin
            h_srcid <= in_srcid;
            h_trdid <= in_trdid;
            h_pktid <= in_pktid;
         end
      end
   end

   assign tr_req   = (state == ST_IDLE) && in_valid && xlat_en;
   assign tr_vaddr = in_addr;

   always_comb begin
      unique case (state)
         ST_FWD_MEM: in_ready = mem_ready;
         ST_FWD_WTI: in_ready = wti_ready;
         ST_DRAIN:   in_ready = 1'b1;
         default:    in_ready = 1'b0;
      endcase
   end

   assign flit_paddr = {pa_line, in_addr[OFS_W-1:0]};
   assign irq_full   = {irq_addr_hi, irq_addr_lo};

   assign mem_valid = (state == ST_FWD_MEM) && in_valid;
   assign mem_addr  = flit_paddr;
   assign mem_wdata = in_wdata;
   assign mem_write = in_write;
   assign mem_srcid = in_srcid;
   assign mem_trdid = in_trdid;
   assign mem_pktid = in_pktid;
   assign mem_eop   = in_eop;

   always_comb begin
      if (state == ST_IRQ_WR) begin
         wti_valid = 1'b1;
         wti_addr  = PA_W'(irq_full);
         wti_data  = WTI_W'(bad_vaddr);
         wti_srcid = SRC_W'(OWN_SRCID);
         wti_trdid = '0;
         wti_pktid = PKT_W'(PKT_FAULT_WTI);
      end else begin
         wti_valid = (state == ST_FWD_WTI) && in_valid;
         wti_addr  = flit_paddr;
         wti_data  = in_wdata[WTI_W-1:0];
         wti_srcid = in_srcid;
         wti_trdid = in_trdid;
         wti_pktid = PKT_W'(PKT_PERIPH_WTI);
      end
   end

   assign rsp_valid = (state == ST_ERR_RSP);
   assign rsp_srcid = h_srcid;
   assign rsp_trdid = h_trdid;
   assign rsp_pktid = h_pktid;
   assign rsp_error = RSP_ERR_CODE;
endmodule

// File: rtl/dmx_translator_chk.sv
module dmx_translator_chk #(
   parameter int VA_W  = 32,
   parameter int PKT_W = 8,
   parameter int SRC_W = 14,
   parameter int TRD_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xlat_en,
   input logic             in_ready,
   input logic             in_write,
   input logic             tr_req,
   input logic [VA_W-1:0]  tr_vaddr,
   input logic             tr_done,
   input logic             tr_miss,
   input logic             tr_fault,
   input logic             tr_writable,
   input logic             mem_valid,
   input logic             wti_valid,
   input logic             wti_ready,
   input logic [PKT_W-1:0] wti_pktid,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic [SRC_W-1:0] rsp_srcid,
   input logic [TRD_W-1:0] rsp_trdid,
   input logic [1:0]       rsp_error,
   input logic [VA_W-1:0]  bad_vaddr,
   input logic [1:0]       err_type
);
   localparam logic [PKT_W-1:0] FAULT_PKT = PKT_W'(dmx_pkg::PKT_FAULT_WTI);

   assert_one_output_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_valid, wti_valid, rsp_valid}));

   assert_bypass_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !xlat_en |-> !tr_req);

   assert_miss_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tr_req && tr_done && tr_miss && !tr_fault && !(in_write && !tr_writable))
      |=> (!in_ready && !mem_valid && !wti_valid));

   assert_fault_logged_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tr_req && tr_done && tr_fault)
      |=> (err_type == dmx_pkg::FLT_PAGE && bad_vaddr == $past(tr_vaddr)));

   assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wti_valid && !wti_ready && wti_pktid == FAULT_PKT)
      |=> (wti_valid && wti_pktid == FAULT_PKT));

   assert_rsp_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_error != 2'b00));

   assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready)
      |=> (rsp_valid && $stable(rsp_srcid) && $stable(rsp_trdid)));
endmodule

bind dmx_translator dmx_translator_chk #(
   .VA_W(VA_W), .PKT_W(PKT_W), .SRC_W(SRC_W), .TRD_W(TRD_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xlat_en    (xlat_en),
   .in_ready   (in_ready),
   .in_write   (in_write),
   .tr_req     (tr_req),
   .tr_vaddr   (tr_vaddr),
   .tr_done    (tr_done),
   .tr_miss    (tr_miss),
   .tr_fault   (tr_fault),
   .tr_writable(tr_writable),
   .mem_valid  (mem_valid),
   .wti_valid  (wti_valid),
   .wti_ready  (wti_ready),
   .wti_pktid  (wti_pktid),
   .rsp_valid  (rsp_valid),
   .rsp_ready  (rsp_ready),
   .rsp_srcid  (rsp_srcid),
   .rsp_trdid  (rsp_trdid),
   .rsp_error  (rsp_error),
   .bad_vaddr  (bad_vaddr),
   .err_type   (err_type)
);

// File: tb/tb_dmx_translator.sv
module tb_dmx_translator;
   localparam int VA_W = 32, PA_W = 40, DATA_W = 64, WTI_W = 32;
   localparam int SRC_W = 14, TRD_W = 4, PKT_W = 8;
   localparam logic [39:0] WBASE = 40'h00_C000_0000;
   localparam logic [39:0] WMASK = 40'hFF_FF00_0000;
   localparam logic [13:0] OWN_SRC = 14'h2A5;
   localparam int MEM_IW = PA_W + DATA_W + 1 + SRC_W + TRD_W + PKT_W + 1;
   localparam int WTI_IW = PA_W + WTI_W + SRC_W + TRD_W + PKT_W;
   localparam int RSP_IW = SRC_W + TRD_W + PKT_W + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xlat_en = 1'b0, irq_en = 1'b0;
   logic [31:0] irq_addr_lo = 32'hCDE0_0040, irq_addr_hi = 32'h0000_00AB;
   logic in_valid = 1'b0, in_write = 1'b0, in_eop = 1'b0;
   logic [VA_W-1:0] in_addr = '0;
   logic [DATA_W-1:0] in_wdata = '0;
   logic [SRC_W-1:0] in_srcid = '0;
   logic [TRD_W-1:0] in_trdid = '0;
   logic [PKT_W-1:0] in_pktid = '0;
   logic tr_done = 1'b0, tr_miss = 1'b0, tr_fault = 1'b0, tr_writable = 1'b1, tr_fill = 1'b0;
   logic [PA_W-1:0] tr_paddr = '0;
   logic mem_ready = 1'b1, wti_ready = 1'b1, rsp_ready = 1'b1;
   logic in_ready, tr_req, mem_valid, mem_write, mem_eop, wti_valid, rsp_valid;
   logic [VA_W-1:0] tr_vaddr, bad_vaddr;
   logic [PA_W-1:0] mem_addr, wti_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic [WTI_W-1:0] wti_data;
   logic [SRC_W-1:0] mem_srcid, wti_srcid, rsp_srcid, bad_srcid;
   logic [TRD_W-1:0] mem_trdid, wti_trdid, rsp_trdid;
   logic [PKT_W-1:0] mem_pktid, wti_pktid, rsp_pktid;
   logic [1:0] rsp_error, err_type;

   always #10 clk = ~clk;

   dmx_translator dut (.*);

   int nchk = 0, nerr = 0;
   logic [MEM_IW-1:0] exp_mem[$];
   logic [WTI_IW-1:0] exp_wti[$];
   logic [RSP_IW-1:0] exp_rsp[$];
   logic [VA_W-1:0] e_bad_va = '0;
   logic [SRC_W-1:0] e_bad_src = '0;
   logic [1:0] e_type = '0;
   bit miss_once = 1'b0;
   bit req_in_bypass = 1'b0;
   bit overlap_seen = 1'b0;
   bit done_flag = 1'b0;

   task automatic check(input bit ok, input string req, input logic [MEM_IW-1:0] act, input logic [MEM_IW-1:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   endtask

   function automatic logic [PA_W-1:0] xl_pa(input logic [VA_W-1:0] va);
      return {8'h00, va[31:24], va[23:12] ^ 12'h5A5, va[11:0]};
   endfunction
   function automatic bit is_flt(input logic [VA_W-1:0] va);
      return va[31:24] == 8'hF0;
   endfunction
   function automatic bit is_ro(input logic [VA_W-1:0] va);
      return va[31:24] == 8'hE0;
   endfunction
   function automatic bit in_win(input logic [PA_W-1:0] pa);
      return (pa & WMASK) == WBASE;
   endfunction

   // translation engine model
   initial begin
      forever begin
         @(negedge clk);
         if (tr_req && !xlat_en) req_in_bypass = 1'b1;
         if (tr_req && !tr_done) begin
            bit was_miss;
            repeat ($urandom_range(0, 2)) @(negedge clk);
            tr_paddr    = xl_pa(tr_vaddr);
            tr_fault    = is_flt(tr_vaddr);
            tr_writable = !is_ro(tr_vaddr);
            was_miss    = miss_once && !is_flt(tr_vaddr);
            tr_miss     = was_miss;
            miss_once   = 1'b0;
            tr_done     = 1'b1;
            @(posedge clk);
            #1 tr_done = 1'b0;
            tr_miss = 1'b0;
            if (was_miss) begin
               repeat (4) @(negedge clk);
               tr_fill = 1'b1;
               @(negedge clk);
               tr_fill = 1'b0;
            end
         end
      end
   end

   // output monitors
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if ($countones({mem_valid, wti_valid, rsp_valid}) > 1) overlap_seen = 1'b1;
            if (mem_valid && mem_ready) begin
               logic [MEM_IW-1:0] a;
               a = {mem_addr, mem_wdata, mem_write, mem_srcid, mem_trdid, mem_pktid, mem_eop};
               if (exp_mem.size() == 0) check(1'b0, "R3/R8 unexpected memory flit", a, '0);
               else begin
                  logic [MEM_IW-1:0] e;
                  e = exp_mem.pop_front();
                  check(a == e, "R3 memory flit", a, e);
               end
            end
            if (wti_valid && wti_ready) begin
               logic [WTI_IW-1:0] a;
               a = {wti_addr, wti_data, wti_srcid, wti_trdid, wti_pktid};
               if (exp_wti.size() == 0) check(1'b0, "R5/R8/R9 unexpected interrupt write", MEM_IW'(a), '0);
               else begin
                  logic [WTI_IW-1:0] e;
                  e = exp_wti.pop_front();
                  check(a == e, "R5/R9 interrupt write", MEM_IW'(a), MEM_IW'(e));
               end
            end
            if (rsp_valid && rsp_ready) begin
               logic [RSP_IW-1:0] a;
               a = {rsp_srcid, rsp_trdid, rsp_pktid, rsp_error};
               check(exp_wti.size() == 0, "R9 fault write before response", MEM_IW'(exp_wti.size()), '0);
               if (exp_rsp.size() == 0) check(1'b0, "R10 unexpected response", MEM_IW'(a), '0);
               else begin
                  logic [RSP_IW-1:0] e;
                  e = exp_rsp.pop_front();
                  check(a == e, "R10 error response", MEM_IW'(a), MEM_IW'(e));
               end
            end
         end
      end
   end

   // random ready stalls
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            mem_ready = ($urandom % 4) != 0;
            wti_ready = ($urandom % 4) != 0;
            rsp_ready = ($urandom % 3) != 0;
         end
      end
   end

   task automatic send_pkt(input logic [VA_W-1:0] va, input int n, input bit wr,
                           input logic [SRC_W-1:0] s, input logic [TRD_W-1:0] t,
                           input logic [PKT_W-1:0] p, input bit miss);
      logic [PA_W-1:0] pa;
      bit flt;
      pa  = xlat_en ? xl_pa(va) : {8'h00, va};
      flt = xlat_en && (is_flt(va) || (wr && is_ro(va)));
      if (flt) begin
         if (irq_en) exp_wti.push_back({irq_addr_hi[7:0], irq_addr_lo, va, OWN_SRC, 4'h0, 8'h0C});
         exp_rsp.push_back({s, t, p, 2'b01});
         e_bad_va = va; e_bad_src = s; e_type = is_flt(va) ? 2'd1 : 2'd2;
      end
      miss_once = miss && xlat_en && !flt;
      for (int i = 0; i < n; i++) begin
         logic [VA_W-1:0] fa;
         logic [DATA_W-1:0] d;
         fa = va + VA_W'(8 * i);
         d  = {$urandom, $urandom};
         in_addr = fa; in_wdata = d; in_write = wr; in_srcid = s; in_trdid = t;
         in_pktid = p; in_eop = (i == n - 1); in_valid = 1'b1;
         if (!flt) begin
            if (in_win(pa)) exp_wti.push_back({pa[PA_W-1:6], fa[5:0], d[31:0], s, t, 8'h04});
            else            exp_mem.push_back({pa[PA_W-1:6], fa[5:0], d, wr, s, t, p, (i == n - 1)});
         end
         forever begin
            @(negedge clk);
            if (in_ready) break;
         end
         @(posedge clk);
         #1;
      end
      in_valid = 1'b0; in_eop = 1'b0;
      while (exp_mem.size() != 0 || exp_wti.size() != 0 || exp_rsp.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      check(bad_vaddr == e_bad_va, "R7 bad vaddr", MEM_IW'(bad_vaddr), MEM_IW'(e_bad_va));
      check(bad_srcid == e_bad_src, "R7 bad srcid", MEM_IW'(bad_srcid), MEM_IW'(e_bad_src));
      check(err_type == e_type, "R7 error type", MEM_IW'(err_type), MEM_IW'(e_type));
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd7331));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(!in_ready && !tr_req, "R1 ready/req in reset", MEM_IW'({in_ready, tr_req}), '0);
      check(!mem_valid && !wti_valid && !rsp_valid, "R1 valids in reset",
            MEM_IW'({mem_valid, wti_valid, rsp_valid}), '0);
      check(err_type == 0 && bad_vaddr == 0 && bad_srcid == 0, "R1 diagnostics in reset",
            MEM_IW'({err_type, bad_vaddr, bad_srcid}), '0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!in_ready && !mem_valid && !wti_valid && !rsp_valid, "R1 idle after reset",
            MEM_IW'({in_ready, mem_valid, wti_valid, rsp_valid}), '0);
      @(posedge clk);
      #1;

      // R2 R3: translated DMA, 4 flits from offset 0x08
      xlat_en = 1'b1;
      send_pkt(32'h1234_5608, 4, 1'b1, 14'h011, 4'h3, 8'h21, 1'b0);
      // R4: bypass, starts at end of line
      xlat_en = 1'b0;
      send_pkt(32'h2345_6738, 1, 1'b0, 14'h012, 4'h4, 8'h22, 1'b0);
      send_pkt(32'h3456_7800, 3, 1'b1, 14'h013, 4'h5, 8'h23, 1'b0);
      check(!req_in_bypass, "R4 no translation request in bypass", MEM_IW'(req_in_bypass), '0);
      // R5: window both modes
      send_pkt(32'hC000_1000, 1, 1'b1, 14'h014, 4'h6, 8'h24, 1'b0);
      xlat_en = 1'b1;
      send_pkt(32'hC012_3010, 2, 1'b1, 14'h015, 4'h7, 8'h25, 1'b0);
      // R6: miss
      send_pkt(32'h4567_8920, 3, 1'b0, 14'h016, 4'h8, 8'h26, 1'b1);
      // R7 R8 R9 R10: page fault with interrupt
      irq_en = 1'b1;
      send_pkt(32'hF000_AB00, 3, 1'b0, 14'h017, 4'h9, 8'h27, 1'b0);
      // R7 read-only write, single flit, interrupt disabled
      irq_en = 1'b0;
      send_pkt(32'hE000_CD18, 1, 1'b1, 14'h018, 4'hA, 8'h28, 1'b0);
      // R7 read-only read goes through
      send_pkt(32'hE000_CD18, 2, 1'b0, 14'h019, 4'hB, 8'h29, 1'b0);

      // random mix
      for (int k = 0; k < 80; k++) begin
         int c, n;
         logic [VA_W-1:0] va;
         c = $urandom % 6;
         n = (c == 2) ? 1 + ($urandom % 2) : 1 + ($urandom % 4);
         va = $urandom;
         case (c)
            2:       va[31:24] = 8'hC0;
            3:       va[31:24] = 8'hF0;
            4:       va[31:24] = 8'hE0;
            default: va[31:24] = 8'h10 + 8'($urandom % 64);
         endcase
         va[5:0] = 6'(8 * ($urandom % (9 - n)));
         xlat_en = ($urandom % 4) != 0;
         irq_en  = $urandom % 2;
         send_pkt(va, n, $urandom % 2, SRC_W'($urandom), TRD_W'($urandom), PKT_W'($urandom), c == 5);
      end

      check(exp_mem.size() == 0 && exp_wti.size() == 0 && exp_rsp.size() == 0, "R3/R5/R10 queues drained",
            MEM_IW'(exp_mem.size() + exp_wti.size() + exp_rsp.size()), '0);
      check(!overlap_seen, "R11 single output valid", MEM_IW'(overlap_seen), '0);
      check(!req_in_bypass, "R4 no request in bypass (random)", MEM_IW'(req_in_bypass), '0);
      finish_run();
   end
endmodule